// File: doc/BRIEF.md
# Integer Compare and Branch Unit

This unit carries out the flow-control and integer relational instructions of a 32-bit register CPU. Each cycle the decode stage may present one instruction: a 6-bit opcode, a flag that picks the second operand, two register values, an immediate and the address of the instruction. The immediate flag selects the immediate as the second operand; otherwise the second register is used. The unit returns a register write-back value with its enable, the address of the next instruction, and a halt flag.

Relational instructions produce a boolean result. The result goes back into the register named as the first operand, so no condition flags are kept. The two conditional jumps test a register directly: one branches when the register is nonzero, the other when it is zero. The halt instruction has the all-zero code, so an empty instruction word stops the machine. The halt flag stays set until reset. Opcodes that belong to other execution units pass through as plain sequential instructions.

Top module: `cbu_unit`

## Requirements
- R1: Opcodes 0x07, 0x08, 0x09, 0x0A, 0x0B and 0x0C compare the first operand with the second as equal, not equal, greater, greater-or-equal, less and less-or-equal, both operands read as signed 32-bit two's complement. wb_en is 1 and wb_data is 1 when the relation holds and 0 otherwise.
- R2: When use_imm is 1 the second operand (compare right side or jump target) is imm_val. When use_imm is 0 it is rb_val.
- R3: Opcode 0x02 always jumps: next_ip equals the second operand and wb_en is 0.
- R4: Opcode 0x05 jumps to the second operand when ra_val is nonzero; wb_en is 0.
- R5: Opcode 0x06 jumps to the second operand when ra_val is exactly zero; wb_en is 0.
- R6: A compare, an untaken conditional jump, or any opcode outside 0x00, 0x02, 0x05 to 0x0C gives next_ip = cur_ip + 2 when use_imm is 1 and cur_ip + 1 when it is 0.
- R7: Opcodes outside 0x07 to 0x0C never raise wb_en, and wb_data is 0 whenever wb_en is 0.
- R8: A valid opcode 0x00 holds next_ip at cur_ip and sets halted from the next clock edge. halted stays 1 until rst_n is asserted, and it is 0 after reset.
- R9: While halted is 1, or while op_valid is 0, wb_en is 0 and next_ip equals cur_ip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 6 | Decoded opcode |
| use_imm | input | 1 | Second operand comes from imm_val, and the instruction is two words long |
| ra_val | input | 32 | First operand register value |
| rb_val | input | 32 | Second operand register value |
| imm_val | input | 32 | Immediate value |
| cur_ip | input | 32 | Address of the current instruction |
| wb_en | output | 1 | Write wb_data into the first operand register |
| wb_data | output | 32 | Write-back value (0 or 1) |
| next_ip | output | 32 | Address of the next instruction |
| halted | output | 1 | Execution stopped |

## Verification
The only state in the unit is the halt register. If that register is wrong, the fault shows one cycle after the halt instruction: halted stays low, or next_ip keeps advancing for later instructions, or halted rises without a halt opcode. The remaining datapath is combinational. A wrong relation select, a wrong signedness or a wrong operand mux therefore shows in the same cycle, as a wrong wb_data or next_ip. The sweep covers all 64 opcodes, both operand sources, and operand pairs that cross the sign boundary.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
   localparam int OPC_W = 6;

   typedef enum logic [OPC_W-1:0] {
      OP_HALT = 6'h00,
      OP_JMP  = 6'h02,
      OP_JT   = 6'h05,
      OP_JF   = 6'h06,
      OP_CEQ  = 6'h07,
      OP_CNE  = 6'h08,
      OP_CGT  = 6'h09,
      OP_CGE  = 6'h0A,
      OP_CLT  = 6'h0B,
      OP_CLE  = 6'h0C
   } opc_e;

   typedef enum logic [2:0] {
      REL_EQ = 3'd0,
      REL_NE = 3'd1,
      REL_GT = 3'd2,
      REL_GE = 3'd3,
      REL_LT = 3'd4,
      REL_LE = 3'd5
   } rel_e;
endpackage

// File: rtl/cbu_compare.sv
module cbu_compare #(
   parameter int DATA_W     = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  cbu_pkg::rel_e     rel,
   output logic              holds
);
   logic is_eq;
   logic is_lt;

   assign is_eq = (lhs == rhs);

   generate
      if (SIGNED_CMP) begin : g_signed
         assign is_lt = $signed(lhs) < $signed(rhs);
      end else begin : g_unsigned
         assign is_lt = lhs < rhs;
      end
   endgenerate

   always_comb begin
      unique case (rel)
         cbu_pkg::REL_EQ: holds = is_eq;
         cbu_pkg::REL_NE: holds = !is_eq;
         cbu_pkg::REL_GT: holds = !is_lt && !is_eq;
         cbu_pkg::REL_GE: holds = !is_lt;
         cbu_pkg::REL_LT: holds = is_lt;
         cbu_pkg::REL_LE: holds = is_lt || is_eq;
         default:         holds = 1'b0;
      endcase
   end
endmodule

// File: rtl/cbu_next_ip.sv
module cbu_next_ip #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] cur_ip,
   input  logic [ADDR_W-1:0] target,
   input  logic              two_words,
   input  logic              hold,
   input  logic              take,
   output logic [ADDR_W-1:0] next_ip
);
   localparam logic [ADDR_W-1:0] LEN_ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] LEN_TWO = ADDR_W'(2);

   logic [ADDR_W-1:0] seq_ip;

   assign seq_ip = cur_ip + (two_words ? LEN_TWO : LEN_ONE);

   always_comb begin
      if (hold)      next_ip = cur_ip;
      else if (take) next_ip = target;
      else           next_ip = seq_ip;
   end
endmodule

// File: rtl/cbu_unit.sv
module cbu_unit #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [5:0]        opcode,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] ra_val,
   input  logic [DATA_W-1:0] rb_val,
   input  logic [DATA_W-1:0] imm_val,
   input  logic [ADDR_W-1:0] cur_ip,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_data,
   output logic [ADDR_W-1:0] next_ip,
   output logic              halted
);
   import cbu_pkg::*;

   localparam int CMP_FIRST = int'(OP_CEQ);
   localparam int CMP_LAST  = int'(OP_CLE);

   generate
      if (DATA_W < 2)         begin : g_bad_data $error("DATA_W must be at least 2"); end
      if (ADDR_W < 2)         begin : g_bad_addr $error("ADDR_W must be at least 2"); end
      if (ADDR_W > DATA_W)    begin : g_bad_fit  $error("ADDR_W must not exceed DATA_W"); end
      if (CMP_LAST - CMP_FIRST != 5) begin : g_bad_map $error("compare opcodes must be contiguous"); end
   endgenerate

   logic              halt_q;
   logic              active;
   logic              is_cmp;
   logic              take;
   logic              hold;
   logic              rel_holds;
   logic [DATA_W-1:0] opnd_b;
   logic [5:0]        rel_off;
   rel_e              rel;

   assign active  = op_valid && !halt_q;
   assign opnd_b  = use_imm ? imm_val : rb_val;
   assign is_cmp  = (opcode >= 6'(CMP_FIRST)) && (opcode <= 6'(CMP_LAST));
   assign rel_off = opcode - 6'(CMP_FIRST);
   assign rel     = rel_e'(rel_off[2:0]);

   cbu_compare #(
      .DATA_W     (DATA_W),
      .SIGNED_CMP (SIGNED_CMP)
   ) i_cmp (
      .lhs   (ra_val),
      .rhs   (opnd_b),
      .rel   (rel),
      .holds (rel_holds)
   );

   always_comb begin
      unique case (opcode)
         OP_JMP:  take = 1'b1;
         OP_JT:   take = (ra_val != '0);
         OP_JF:   take = (ra_val == '0);
         default: take = 1'b0;
      endcase
   end

   assign hold = !active || (opcode == OP_HALT);

   cbu_next_ip #(
      .ADDR_W (ADDR_W)
   ) i_nip (
      .cur_ip    (cur_ip),
      .target    (opnd_b[ADDR_W-1:0]),
      .two_words (use_imm),
      .hold      (hold),
      .take      (take),
      .next_ip   (next_ip)
   );

   assign wb_en   = active && is_cmp;
   assign wb_data = {{(DATA_W-1){1'b0}}, wb_en && rel_holds};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                halt_q <= 1'b0;
      else if (active && (opcode == OP_HALT))    halt_q <= 1'b1;
   end

   assign halted = halt_q;
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [5:0]        opcode,
   input logic              use_imm,
   input logic [ADDR_W-1:0] cur_ip,
   input logic              wb_en,
   input logic [DATA_W-1:0] wb_data,
   input logic [ADDR_W-1:0] next_ip,
   input logic              halted
);
   a_r1_bool_result: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_data == DATA_W'(0) || wb_data == DATA_W'(1)));

   a_r6_cmp_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (next_ip == cur_ip + (use_imm ? ADDR_W'(2) : ADDR_W'(1))));

   a_r7_no_wb_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode < 6'h07 || opcode > 6'h0C) |-> !wb_en);

   a_r7_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_en |-> (wb_data == '0));

   a_r8_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == 6'h00) |=> halted);

   a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   a_r9_halted_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (halted || !op_valid) |-> (!wb_en && next_ip == cur_ip));
endmodule

bind cbu_unit cbu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cbu_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .opcode   (opcode),
   .use_imm  (use_imm),
   .cur_ip   (cur_ip),
   .wb_en    (wb_en),
   .wb_data  (wb_data),
   .next_ip  (next_ip),
   .halted   (halted)
);

// File: tb/test_cbu_unit.sv
module test_cbu_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [5:0]  opcode = '0;
   logic        use_imm = 1'b0;
   logic [31:0] ra_val = '0;
   logic [31:0] rb_val = '0;
   logic [31:0] imm_val = '0;
   logic [31:0] cur_ip = '0;
   logic        wb_en;
   logic [31:0] wb_data;
   logic [31:0] next_ip;
   logic        halted;

   int n_checks = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cbu_unit i_cbu_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .use_imm(use_imm), .ra_val(ra_val), .rb_val(rb_val), .imm_val(imm_val),
      .cur_ip(cur_ip), .wb_en(wb_en), .wb_data(wb_data), .next_ip(next_ip),
      .halted(halted)
   );

   task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (op %h imm %0d)", req, act, exp, opcode, use_imm);
      end
   endtask

   // Reference model built from the requirement text
   task automatic model(input logic [5:0] op, input logic ui, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] im, input logic [31:0] ip,
                        output logic [95:0] exp, output string req);
      int sa = int'(a);
      int sb = int'(ui ? im : b);
      logic [31:0] tgt = ui ? im : b;
      logic [31:0] seq = ip + (ui ? 32'd2 : 32'd1);
      logic e = 1'b0;
      logic r = 1'b0;
      logic [31:0] n = seq;
      req = "R6";
      case (op)
         6'h02: begin n = tgt; req = "R3"; end
         6'h05: begin n = (a != 0) ? tgt : seq; req = "R4"; end
         6'h06: begin n = (a == 0) ? tgt : seq; req = "R5"; end
         6'h07: begin e = 1; r = (sa == sb); req = "R1"; end
         6'h08: begin e = 1; r = (sa != sb); req = "R1"; end
         6'h09: begin e = 1; r = (sa >  sb); req = "R1"; end
         6'h0A: begin e = 1; r = (sa >= sb); req = "R1"; end
         6'h0B: begin e = 1; r = (sa <  sb); req = "R1"; end
         6'h0C: begin e = 1; r = (sa <= sb); req = "R1"; end
         default: req = "R7";
      endcase
      exp = {31'd0, e, 31'd0, r, n};
   endtask

   initial begin
      #400000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] avals [8];
      logic [31:0] bvals [8];
      logic [95:0] exp;
      string req;
      avals = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'd5, 32'd5, 32'hFFFFFFFE};
      bvals = '{32'h0, 32'h0, 32'h1, 32'h80000000, 32'h7FFFFFFF, 32'd5, 32'd6, 32'hFFFFFFFF};

      #3;
      check("R8 reset", {95'd0, halted}, 96'd0);
      @(negedge clk); rst_n = 1'b1;

      // R9: idle input gives no write and a held pointer
      cur_ip = 32'h100; opcode = 6'h07; ra_val = 1; rb_val = 1; op_valid = 1'b0;
      #2; check("R9 idle", {31'd0, wb_en, wb_data, next_ip}, {64'd0, 32'h100});

      // Sweep every non-halt opcode, both operand sources, all operand pairs
      for (int op = 1; op < 64; op++) begin
         for (int ui = 0; ui < 2; ui++) begin
            for (int k = 0; k < 8; k++) begin
               @(negedge clk);
               op_valid = 1'b1; opcode = 6'(op); use_imm = ui[0];
               ra_val = avals[k];
               // R2: the unused source carries a decoy value
               rb_val  = ui ? 32'hDEAD0000 : bvals[k];
               imm_val = ui ? bvals[k] : 32'h0BAD0000;
               cur_ip = 32'h1000 + 32'(op * 16 + k);
               #2;
               model(opcode, use_imm, ra_val, rb_val, imm_val, cur_ip, exp, req);
               check(ui ? {req, " R2 imm"} : {req, " R2 reg"},
                     {31'd0, wb_en, wb_data, next_ip}, exp);
            end
         end
      end

      // R8: halt holds the pointer, then sticks
      @(negedge clk);
      opcode = 6'h00; use_imm = 1'b0; cur_ip = 32'h2000;
      #2; check("R8 halt hold ip", {31'd0, wb_en, 32'd0, next_ip}, {64'd0, 32'h2000});
      check("R8 not yet halted", {95'd0, halted}, 96'd0);
      @(negedge clk);
      check("R8 halted", {95'd0, halted}, 96'd1);
      // R9: halted machine ignores a compare and a jump
      opcode = 6'h07; ra_val = 3; rb_val = 3; cur_ip = 32'h2001;
      #2; check("R9 halted cmp", {31'd0, wb_en, wb_data, next_ip}, {64'd0, 32'h2001});
      @(negedge clk);
      opcode = 6'h02; rb_val = 32'h5555;
      #2; check("R9 halted jmp", {31'd0, wb_en, wb_data, next_ip}, {64'd0, 32'h2001});
      op_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 sticky", {95'd0, halted}, 96'd1);
      rst_n = 1'b0;
      #2; check("R8 reset clears", {95'd0, halted}, 96'd0);
      @(negedge clk); rst_n = 1'b1;
      op_valid = 1'b1; opcode = 6'h0B; ra_val = 32'hFFFFFFFF; rb_val = 0; use_imm = 0;
      cur_ip = 32'h30;
      #2; check("R1 after reset", {31'd0, wb_en, wb_data, next_ip}, {31'd0, 1'b1, 32'd1, 32'h31});

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule